// File: doc/BRIEF.md
# Converter Serial Output Port with Daisy-Chain

This block is the digital pin logic on the device side of a sampling converter's serial port. It watches four pins: a convert strobe (`cnv`), a serial input (`sdi`), a serial clock (`sck`) and a serial output with its tri-state enable (`sdo`, `sdo_oe`). The conversion engine hands it a 16-bit straight-binary result and a one-cycle completion strobe. The rising edge of the convert strobe chooses one of four output personalities. These are select mode with or without a busy start bit, and chain mode with or without a busy bit. Chain mode lets several devices share one data line, because each device passes its serial input through its own result register.

The pins are sampled with the block clock `clk`, and the host is assumed to have synchronised them already. An edge on a pin is seen at the first `clk` edge where the sampled level differs from the level held from the previous cycle. Both outputs are registers that change only at that `clk` edge. The data moves most significant bit first.

Top module: `adc_serial_port`

## Requirements
- R1: At a `cnv` rising edge the mode is latched. `sdi` high selects select mode and `sdi` low selects chain mode. The choice holds until the next `cnv` rising edge.
- R2: A `cnv` rising edge releases `sdo_oe` (drives it low) in the clock after that edge is seen, in either mode.
- R3: Select mode, no busy bit. Once the result is ready, the port is selected when `cnv` or `sdi` is low. The first selection drives `sdo_oe` high with the result MSB on `sdo`. Each following `sck` falling edge presents the next lower bit. The 16th falling edge releases `sdo_oe`. Before selection `sdo_oe` stays low.
- R4: Select mode, busy bit. If the port is selected in the cycle the completion strobe arrives, `sdo_oe` goes high with `sdo` low, which forms a start bit. Falling edges 1 to 16 then present bits 15 down to 0, and the 17th falling edge releases `sdo_oe`.
- R5: In select mode, deselecting the port (`cnv` and `sdi` both high) during a read releases `sdo_oe` in the next clock. A later selection does not resume the read before a new conversion.
- R6: In chain mode the busy bit is enabled if `sck` is high at the `cnv` rising edge, and disabled if `sck` is low.
- R7: Chain mode, no busy bit. The completion strobe drives `sdo_oe` high with the result MSB. Each `sck` falling edge shifts the `sdi` level into the register and presents the next bit. The `sdi` level sampled at falling edge k appears on `sdo` after falling edge k+15, so N chained devices read out in 16×N clocks. `sdo_oe` stays high until the next `cnv` rising edge.
- R8: Chain mode, busy bit. The completion strobe drives `sdo` low with `sdo_oe` high. Until the first falling edge, `sdo` then follows the `sdi` level, so the device nearest the host rises once every device upstream has finished. The first falling edge presents the MSB without shifting. Later edges behave as in R7, and the `sdi` level at edge k appears after edge k+15.
- R9: `sck` falling edges change nothing while a conversion is in progress, and nothing in select mode while `sdo_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that samples the pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cnv | input | 1 | Convert strobe; a rising edge starts a conversion and latches the mode |
| sdi | input | 1 | Mode select at the convert edge; select line or chain data input |
| sck | input | 1 | Serial clock; data advances on its falling edge |
| result | input | 16 | Conversion result, straight binary |
| done | input | 1 | One-cycle strobe from the conversion engine when `result` is valid |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Output enable for `sdo`; low means high impedance |

## Verification
The hardest state to reach is chain mode with the busy bit. It needs `sck` held high through the convert edge and then brought low while the conversion runs. That falling edge must be ignored. After that `sdi` has to be toggled before the first real clock, so that the pass-through level shows on `sdo`. The stimulus sets up exactly this order. It also ends a select-mode read part way through by raising `sdi` while `cnv` stays high, then selects again, so the block shows that a deselected read does not restart.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CONV = 2'd1,
    PH_DATA = 2'd2
  } phase_t;

  // Falling edge at which a select-mode read ends.
  function automatic int read_end_edge(int word_w, logic busy);
    return word_w + (busy ? 1 : 0);
  endfunction

  // Port deselected only when both select wires are high.
  function automatic logic port_idle(logic cnv_lvl, logic sdi_lvl);
    return cnv_lvl & sdi_lvl;
  endfunction

endpackage

// File: rtl/adc_sp_edges.sv
module adc_sp_edges #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] held;

  always_ff @(posedge clk) begin
    if (!rst_n) held <= '0;
    else        held <= lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign rise[i] = lvl[i] & ~held[i];
    assign fall[i] = ~lvl[i] & held[i];
  end
endmodule

// File: rtl/adc_sp_shreg.sv
module adc_sp_shreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  input  logic         ser_in,
  output logic         top_bit,
  output logic         next_bit
);
  logic [W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     word_q <= '0;
    else if (load)  word_q <= din;
    else if (shift) word_q <= {word_q[W-2:0], ser_in};
  end

  assign top_bit  = word_q[W-1];
  assign next_bit = word_q[W-2];
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv,
  input  logic              sdi,
  input  logic              sck,
  input  logic [WORD_W-1:0] result,
  input  logic              done,
  output logic              sdo,
  output logic              sdo_oe
);
  import adc_sp_pkg::*;

  localparam int CNT_W = $clog2(WORD_W + 2);

  // Pin edges, named for the assertions
  logic [2:0] lvl, rise, fall;
  logic       idle_now;
  assign idle_now = port_idle(cnv, sdi);
  assign lvl      = {idle_now, sck, cnv};

  adc_sp_edges #(.N(3)) u_edges (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise), .fall(fall)
  );

  logic cnv_rise, sck_fall, desel_evt, sel_evt;
  assign cnv_rise  = rise[0];
  assign sck_fall  = fall[1];
  assign desel_evt = rise[2];
  assign sel_evt   = fall[2];

  phase_t             phase;
  logic               chain_m, busy_m, oe_q, sdo_q;
  logic [CNT_W-1:0]   cnt;
  logic               data_ph, load_evt, first_edge, last_edge;
  logic               top_bit, next_bit, do_shift;

  assign data_ph    = (phase == PH_DATA) && !cnv_rise;
  assign load_evt   = done && (phase == PH_CONV) && !cnv_rise;
  assign first_edge = busy_m && (cnt == '0);
  assign last_edge  = (int'(cnt) + 1) == read_end_edge(WORD_W, busy_m);

  assign do_shift = data_ph && sck_fall && !first_edge &&
                    (chain_m || (oe_q && !desel_evt));

  adc_sp_shreg #(.W(WORD_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .load(load_evt), .din(result),
    .shift(do_shift), .ser_in(sdi & chain_m),
    .top_bit(top_bit), .next_bit(next_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      chain_m <= 1'b0;
      busy_m  <= 1'b0;
      oe_q    <= 1'b0;
      sdo_q   <= 1'b0;
      cnt     <= '0;
    end else if (cnv_rise) begin
      chain_m <= !sdi;
      busy_m  <= !sdi && sck;
      phase   <= PH_CONV;
      oe_q    <= 1'b0;
      cnt     <= '0;
    end else if (load_evt) begin
      phase <= PH_DATA;
      cnt   <= '0;
      if (chain_m) begin
        oe_q  <= 1'b1;
        sdo_q <= busy_m ? 1'b0 : result[WORD_W-1];
      end else if (!idle_now) begin
        busy_m <= 1'b1;
        oe_q   <= 1'b1;
        sdo_q  <= 1'b0;
      end else begin
        busy_m <= 1'b0;
      end
    end else if (data_ph) begin
      if (!chain_m) begin
        if (desel_evt) begin
          oe_q  <= 1'b0;
          phase <= PH_IDLE;
        end else if (oe_q && sck_fall) begin
          cnt <= cnt + 1'b1;
          if (last_edge) begin
            oe_q  <= 1'b0;
            phase <= PH_IDLE;
          end else begin
            sdo_q <= first_edge ? top_bit : next_bit;
          end
        end else if (!oe_q && sel_evt) begin
          oe_q  <= 1'b1;
          sdo_q <= top_bit;
        end
      end else begin
        if (sck_fall) begin
          if (cnt != '1) cnt <= cnt + 1'b1;
          sdo_q <= first_edge ? top_bit : next_bit;
        end else if (first_edge) begin
          sdo_q <= sdi;
        end
      end
    end
  end

  assign sdo    = sdo_q;
  assign sdo_oe = oe_q;

  // R2
  cnv_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_rise |=> !sdo_oe);

  // R4
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !chain_m && !idle_now) |=> (sdo_oe && !sdo));

  // R7
  chain_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && chain_m && !busy_m) |=> (sdo_oe && sdo == $past(result[WORD_W-1])));

  // R5
  desel_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ph && !chain_m && oe_q && desel_evt) |=> !sdo_oe);

  // R9
  oe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> $past(load_evt || sel_evt));

endmodule

// File: tb/test_adc_serial_port.sv
module test_adc_serial_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnv = 1'b0, sdi = 1'b0, sck = 1'b0, done = 1'b0;
  logic [15:0] result = '0;
  logic sdo, sdo_oe;

  int vec_cnt = 0;
  int err_cnt = 0;
  string tag = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_serial_port i_adc_serial_port (
    .clk(clk), .rst_n(rst_n), .cnv(cnv), .sdi(sdi), .sck(sck),
    .result(result), .done(done), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  // Behavioural reference: a bit queue per read
  bit m_pc, m_ps, m_pi, m_chain, m_busy, m_conv, m_data, m_started, m_oe, m_sdo;
  bit q[$];

  always @(posedge clk) begin
    bit cr, sf, si, sr, sfl;
    if (!rst_n) begin
      m_pc = 0; m_ps = 0; m_pi = 0; m_chain = 0; m_busy = 0; m_conv = 0;
      m_data = 0; m_started = 0; m_oe = 0; m_sdo = 0; q.delete();
    end else begin
      si  = cnv && sdi;
      cr  = cnv && !m_pc;
      sf  = !sck && m_ps;
      sr  = si && !m_pi;
      sfl = !si && m_pi;
      if (cr) begin
        m_chain = !sdi; m_busy = !sdi && sck; m_conv = 1; m_data = 0;
        m_oe = 0; m_started = 0; q.delete();
      end else if (done && m_conv) begin
        m_conv = 0; m_data = 1; q.delete();
        for (int b = 15; b >= 0; b--) q.push_back(result[b]);
        if (m_chain) begin
          m_oe = 1;
          if (m_busy) m_sdo = 0; else m_sdo = q.pop_front();
          m_started = !m_busy;
        end else if (!si) begin
          m_busy = 1; m_oe = 1; m_sdo = 0; m_started = 1;
        end else begin
          m_busy = 0; m_started = 0;
        end
      end else if (m_data) begin
        if (!m_chain) begin
          if (sr) begin m_oe = 0; m_data = 0; end
          else if (m_oe && sf) begin
            if (q.size() == 0) begin m_oe = 0; m_data = 0; end
            else m_sdo = q.pop_front();
          end else if (!m_oe && sfl && !m_started) begin
            m_oe = 1; m_sdo = q.pop_front(); m_started = 1;
          end
        end else begin
          if (sf) begin
            if (!m_started) begin m_sdo = q.pop_front(); m_started = 1; end
            else begin q.push_back(sdi); m_sdo = q.pop_front(); end
          end else if (!m_started) m_sdo = sdi;
        end
      end
      m_pc = cnv; m_ps = sck; m_pi = si;
    end
  end

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      vec_cnt++;
      if (sdo_oe !== m_oe || (m_oe && sdo !== m_sdo)) begin
        err_cnt++;
        $display("FAIL %s t=%0t oe/sdo actual %b/%b expected %b/%b",
                 tag, $time, sdo_oe, sdo, m_oe, m_sdo);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic act, logic exp);
    vec_cnt++;
    if (act !== exp) begin
      err_cnt++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic clock_bits(int n, logic [63:0] pat, bit drv);
    for (int i = 0; i < n; i++) begin
      sck = 1'b1;
      if (drv) sdi = pat[i];
      step(2);
      sck = 1'b0;
      step(2);
    end
  endtask

  task automatic pulse_done(logic [15:0] w);
    result = w; done = 1'b1;
    step(1);
    done = 1'b0;
    step(1);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    err_cnt++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    step(4);
    rst_n = 1'b1;
    step(2);
    chk("R2 reset", sdo_oe, 1'b0);

    // R1 R3: select mode, select by sdi
    tag = "R3";
    sdi = 1'b1; step(2);
    cnv = 1'b1; step(3);
    pulse_done(16'hA5C3); step(2);
    chk("R3 not driven before select", sdo_oe, 1'b0);
    sdi = 1'b0; step(2);
    chk("R1 R3 select drives", sdo_oe, 1'b1);
    chk("R3 msb", sdo, 1'b1);
    clock_bits(15, '0, 1'b0);
    chk("R3 lsb", sdo, 1'b1);
    clock_bits(1, '0, 1'b0);
    chk("R3 release after 16", sdo_oe, 1'b0);
    sdi = 1'b1; step(2);

    // R4: select mode with busy start bit
    tag = "R4";
    cnv = 1'b0; step(2);
    cnv = 1'b1; step(2);
    cnv = 1'b0; step(2);
    pulse_done(16'h3C5A);
    chk("R4 start bit oe", sdo_oe, 1'b1);
    chk("R4 start bit low", sdo, 1'b0);
    clock_bits(16, '0, 1'b0);
    chk("R4 still driven at 16", sdo_oe, 1'b1);
    clock_bits(1, '0, 1'b0);
    chk("R4 release after 17", sdo_oe, 1'b0);

    // R5 R9: deselect during read
    tag = "R5";
    sdi = 1'b1; step(2);
    cnv = 1'b1; step(3);
    pulse_done(16'hFFFF);
    sdi = 1'b0; step(2);
    clock_bits(5, '0, 1'b0);
    sdi = 1'b1; step(2);
    chk("R5 deselect releases", sdo_oe, 1'b0);
    sdi = 1'b0; step(2);
    chk("R5 no resume", sdo_oe, 1'b0);
    tag = "R9";
    clock_bits(3, '0, 1'b0);
    chk("R9 falls ignored", sdo_oe, 1'b0);
    sdi = 1'b1; step(2);

    // R1 R6 R7: chain without busy
    tag = "R7";
    cnv = 1'b0; sdi = 1'b0; step(2);
    cnv = 1'b1; step(2);
    clock_bits(2, '0, 1'b0);
    chk("R9 falls during conversion", sdo_oe, 1'b0);
    pulse_done(16'h8001);
    chk("R7 oe at done", sdo_oe, 1'b1);
    chk("R7 msb at done", sdo, 1'b1);
    clock_bits(16, 64'h0000_0000_C3A5_96E1, 1'b1);
    chk("R7 sdi delayed 16", sdo, 1'b1);
    clock_bits(16, 64'h0000_0000_5A5A_0F0F, 1'b1);
    chk("R7 stays driven", sdo_oe, 1'b1);

    // R6 R8: chain with busy
    tag = "R8";
    cnv = 1'b0; sdi = 1'b0; sck = 1'b1; step(2);
    cnv = 1'b1; step(2);
    chk("R2 chain release", sdo_oe, 1'b0);
    sck = 1'b0; step(3);
    pulse_done(16'h9234);
    chk("R6 R8 busy low", sdo, 1'b0);
    sdi = 1'b1; step(2);
    chk("R8 follows sdi high", sdo, 1'b1);
    sdi = 1'b0; step(2);
    chk("R8 follows sdi low", sdo, 1'b0);
    clock_bits(1, '0, 1'b0);
    chk("R8 msb on first edge", sdo, 1'b1);
    clock_bits(20, 64'h0000_0000_000F_3A6C, 1'b1);

    // R2: convert edge during chain output
    tag = "R2";
    cnv = 1'b0; step(2);
    chk("R2 oe before edge", sdo_oe, 1'b1);
    cnv = 1'b1; sdi = 1'b1; step(2);
    chk("R2 edge releases", sdo_oe, 1'b0);
    step(4);

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule